// File: doc/BRIEF.md
# Rotating Device Service-Request Poller

This block watches ten level-sensitive service-request lines, one per device, and picks one device at a time to hand to the processor. A pointer walks round the devices in a fixed circular order and tests one device each clock cycle. When the device under the pointer is requesting, the pointer stops and holds that device number. It stays frozen until the processor raises its take strobe.

In the take cycle the block presents the held number as a decimal digit, together with a flag saying a number is being delivered. It also releases the hold. Scanning then carries on from the device after the one just served, so a device that keeps requesting cannot lock out its neighbours. A take that arrives while nothing is held delivers nothing and leaves the scan undisturbed.

Top module: `svc_poll`

## Requirements
- R1: While nothing is held, the pointer tests one device per clock cycle. When the tested device is not requesting, the pointer moves to the next higher device, and device 9 is followed by device 0.
- R2: While nothing is held, a request on the device under the pointer captures that device number at the clock edge, and scanning stops.
- R3: A held number stays unchanged, whatever the request lines do, until a take is seen. This includes the held device's own request dropping.
- R4: A take while a number is held drives `pend_o` = 1 and `dev_o` = the held number, as BCD 0 to 9, in that same cycle. The hold is released at the following clock edge.
- R5: After a release, the first device tested is the one after the device just served, with 9 wrapping to 0. A device still requesting is therefore served again only after the others have had their turn.
- R6: A take while nothing is held gives `pend_o` = 0 and `dev_o` = 0 and does not alter the scan order or timing.
- R7: When a take and a capture fall in the same cycle, the capture happens and the take reports nothing. The captured number is delivered by a later take.
- R8: A synchronous active-low reset clears any held number and sets the pointer to device 0.
- R9: `dev_o` is 0 in every cycle in which `pend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 10 | Service-request level per device, bit n for device n |
| take_i | input | 1 | Processor take strobe |
| dev_o | output | 4 | Delivered device number, BCD, 0 when nothing is delivered |
| pend_o | output | 1 | High in a take cycle that delivers a held number |

## Verification
A take strobe and a fresh capture can meet in one cycle. This happens when the processor asks while the pointer has just reached a requesting device. The bench provokes it by raising take together with requests on two neighbouring devices, in the very cycle the pointer arrives at the first of them. It expects no delivery in that cycle and the first device on the next take. Holding take high on the following cycles then shows the pointer resuming at the second device rather than skipping it. The same approach, with counted cycles, shows that a take on an idle scanner does not shift the moment of the next capture.

// File: rtl/svc_poll_pkg.sv
// Shared types for the service-request poller.
// Assumes: nothing beyond the two operating states listed here.
package svc_poll_pkg;

    // Operating state of the poller: scanning or holding a captured device
    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } svc_state_e;

endpackage

// File: rtl/svc_scan_ptr.sv
// Circular device pointer.
// What it does: steps to the next device on 'step', wrapping from the last
// device to device 0, and resets to device 0.
// Assumes: NDEV fits in PW bits.
module svc_scan_ptr #(
    parameter int NDEV = 10,
    parameter int PW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(NDEV - 1);

    // Pointer register: reset to device 0, advance with wrap on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
        end
    end
endmodule

// File: rtl/svc_req_sel.sv
// Request selector.
// What it does: reports whether the device under the pointer is requesting,
// through a decoded one-hot match rather than a variable bit index.
// Assumes: ptr never exceeds NDEV-1.
module svc_req_sel #(
    parameter int NDEV = 10,
    parameter int PW   = 4
) (
    input  logic [NDEV-1:0] req,
    input  logic [PW-1:0]   ptr,
    output logic            hit
);
    logic [NDEV-1:0] match;

    // One comparator per device line
    for (genvar i = 0; i < NDEV; i++) begin : g_match
        assign match[i] = req[i] && (ptr == PW'(i));
    end

    // Any matching line is a hit
    assign hit = |match;
endmodule

// File: rtl/svc_hold.sv
// Hold controller.
// What it does: enters the hold state on a hit while scanning and returns
// to scanning on a take while holding.
// Assumes: hit and take are synchronous to clk.
module svc_hold
    import svc_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic take,
    output logic held
);
    svc_state_e state_q;

    // State register: capture on hit, release on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            unique case (state_q)
                ST_SCAN: if (hit)  state_q <= ST_HOLD;
                ST_HOLD: if (take) state_q <= ST_SCAN;
                default:           state_q <= ST_SCAN;
            endcase
        end
    end

    assign held = (state_q == ST_HOLD);
endmodule

// File: rtl/svc_poll.sv
// Rotating service-request poller (top).
// What it does: scans the request lines one device per cycle, freezes on
// the first requesting device met, and delivers its number on a take.
// Holding is done by stopping the pointer, so the pointer is the number.
// Assumes: request lines are already synchronous to clk.
module svc_poll #(
    parameter int NDEV = 10,
    parameter int PW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDEV-1:0] req_i,
    input  logic            take_i,
    output logic [PW-1:0]   dev_o,
    output logic            pend_o
);
    logic [PW-1:0] ptr;
    logic          hit;
    logic          held;
    logic          step;

    // Pointer moves on a miss while scanning, or on a release while holding
    always_comb begin
        step = held ? take_i : !hit;
    end

    svc_scan_ptr #(.NDEV(NDEV), .PW(PW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ptr   (ptr)
    );

    svc_req_sel #(.NDEV(NDEV), .PW(PW)) u_sel (
        .req (req_i),
        .ptr (ptr),
        .hit (hit)
    );

    svc_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .take  (take_i),
        .held  (held)
    );

    // Delivery: number and flag only in a take cycle with a held number
    always_comb begin
        pend_o = held && take_i;
        dev_o  = pend_o ? ptr : '0;
    end
endmodule

// File: rtl/svc_poll_chk.sv
// Property checker for svc_poll, attached with bind.
// What it does: relates pointer, hold state and delivery outputs over time.
// Assumes: it sees the top's internal ptr and held signals.
module svc_poll_chk #(
    parameter int NDEV = 10,
    parameter int PW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NDEV-1:0] req_i,
    input logic            take_i,
    input logic [PW-1:0]   dev_o,
    input logic            pend_o,
    input logic            held,
    input logic [PW-1:0]   ptr
);
    localparam logic [PW-1:0] LAST = PW'(NDEV - 1);

    logic cur_req;
    logic [PW-1:0] ptr_nxt;

    // Request seen at the pointer and the device after the pointer
    always_comb begin
        cur_req = |(req_i & (NDEV'(1) << ptr));
        ptr_nxt = (ptr == LAST) ? '0 : ptr + PW'(1);
    end

    // R1: a miss while scanning moves to the next device
    p_scan_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !cur_req) |=> (!held && ptr == $past(ptr_nxt)));

    // R1: the pointer never leaves the device range
    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R2: a request at the pointer is captured and the pointer freezes
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && cur_req) |=> (held && ptr == $past(ptr)));

    // R3: without a take the hold and its number persist
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !take_i) |=> (held && $stable(ptr)));

    // R4: a delivery carries the held number
    p_deliver_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (held && dev_o == ptr));

    // R5: a release resumes at the device after the one served
    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held && take_i) |=> (!held && ptr == $past(ptr_nxt)));

    // R6: a take with nothing held delivers nothing
    p_idle_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && take_i) |-> !pend_o);

    // R9: the number output is zero whenever nothing is delivered
    p_zero_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (dev_o == '0));
endmodule

bind svc_poll svc_poll_chk #(.NDEV(NDEV), .PW(PW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .take_i (take_i),
    .dev_o  (dev_o),
    .pend_o (pend_o),
    .held   (held),
    .ptr    (ptr)
);

// File: tb/svc_poll_test.sv
// Directed bench for svc_poll: one task per scenario. Inputs change just
// after a falling edge and outputs are sampled 2 ns later, so each drive
// block covers exactly one rising edge.
module svc_poll_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req_i = '0;
    logic       take_i = 1'b0;
    logic [3:0] dev_o;
    logic       pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    svc_poll uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .take_i (take_i),
        .dev_o  (dev_o),
        .pend_o (pend_o)
    );

    function automatic logic [9:0] dv(input int n);
        return 10'(1) << n;
    endfunction

    // Compare outputs against expected values
    task automatic chk(input string tag, input logic ep, input logic [3:0] ed);
        checks++;
        if (pend_o !== ep || dev_o !== ed) begin
            errors++;
            $display("FAIL %s: pend=%0b dev=%0d expected pend=%0b dev=%0d",
                     tag, pend_o, dev_o, ep, ed);
        end
    endtask

    // One drive block: set inputs for the next rising edge, sample outputs
    task automatic drive(input logic t, input logic [9:0] r);
        @(negedge clk);
        take_i = t;
        req_i  = r;
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, req_i);
    endtask

    // R8 R6: reset state, take with nothing held (edge E1, pointer 0->1)
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        take_i = 1'b1;
        req_i = '0;
        #2;
        chk("R8 reset outputs / R6 idle take", 1'b0, 4'd0);
    endtask

    // R1 R2 R3 R4: scan to device 5, hold through request drop, deliver
    task automatic t_capture_hold;
        drive(1'b0, dv(5));            // E2: 1->2
        chk("R9 no delivery without take", 1'b0, 4'd0);
        idle(7);                       // E3..E9, capture of 5 at E6
        drive(1'b0, '0);               // E10: request drops
        idle(1);                       // E11
        chk("R3 held but no take shows nothing", 1'b0, 4'd0);
        drive(1'b1, '0);               // E12: release, pointer -> 6
        chk("R4 R3 deliver device 5 after drop", 1'b1, 4'd5);
    endtask

    // R5 R1 R6: rotation order and wrap 9->0, exact capture timing
    task automatic t_rotate_wrap;
        drive(1'b0, dv(3) | dv(7));    // E13: 6->7
        idle(2);                       // E14 capture 7, E15
        drive(1'b1, req_i);            // E16: release, pointer 8
        chk("R5 R1 rotation serves 7 before 3", 1'b1, 4'd7);
        drive(1'b1, req_i);            // E17: idle take, 8->9
        chk("R6 take with nothing held", 1'b0, 4'd0);
        idle(5);                       // E18 9->0 .. E22 capture 3
        drive(1'b1, req_i);            // E23: release, pointer 4
        chk("R1 R6 wrap and exact capture of 3", 1'b1, 4'd3);
    endtask

    // R7 R5: take and capture in one cycle, then resume after served
    task automatic t_collide;
        drive(1'b1, dv(4) | dv(5));    // E24: capture 4, take ignored
        chk("R7 take meets capture", 1'b0, 4'd0);
        drive(1'b1, req_i);            // E25: release, pointer 5
        chk("R7 captured device later delivered", 1'b1, 4'd4);
        drive(1'b1, req_i);            // E26: capture 5
        chk("R5 R7 no delivery on capture cycle", 1'b0, 4'd0);
        drive(1'b1, req_i);            // E27: release, pointer 6
        chk("R5 next device after served one", 1'b1, 4'd5);
    endtask

    // R8: reset while holding clears hold and restarts at device 0
    task automatic t_reset_hold;
        drive(1'b0, dv(6));            // E28: capture 6
        @(negedge clk);                // E29: reset
        rst_n = 1'b0;
        take_i = 1'b0;
        #2;
        @(negedge clk);                // E30: scan device 0
        rst_n = 1'b1;
        take_i = 1'b1;
        req_i = dv(0) | dv(1) | dv(6);
        #2;
        chk("R8 hold cleared by reset", 1'b0, 4'd0);
        drive(1'b1, req_i);            // E31
        chk("R8 scan restarts at device 0", 1'b1, 4'd0);
        drive(1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_capture_hold();
        t_rotate_wrap();
        t_collide();
        t_reset_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule